// File: doc/BRIEF.md
# Synchronous Byte-Lane Write SRAM

This block is a clocked, single-port static RAM whose data word is divided into byte lanes of nine bits each. By default there are four lanes, giving a 36-bit word. A parameter selects two lanes for an 18-bit word. Every control input is sampled on the rising clock edge:

- an active-low select
- an active-low global write
- one active-low write strobe per lane
- a sleep request

A read fetches the whole word into an output register, so the data appears one cycle after the address is sampled. A write updates only the lanes whose strobes are low. A write with no strobe active is an aborted cycle that leaves the array untouched.

The bidirectional bus is split into a data input, a data output and a drive-enable flag. The drive-enable stands in for the tri-state control: when it is low the output is treated as high impedance and reads as zero. An active-low output enable and the sleep input both gate the drive combinationally. Sleep drops the drive at once without waiting for a clock edge. The array has no reset. Only the read register and its valid flag are cleared, so stored words survive reset, deselect and sleep.

Top module: `lane_write_sram`

## Requirements
- R1: Lane k occupies data bits [9k+8:9k]. Lane strobe bit k (laneWrN[k]) is active low and controls only that lane.
- R2: With sleep low, selN low and wrN high at a rising edge, the full word at addr is loaded into the read register. After that edge it is presented on dOut, with dOutEn high while oeN is low.
- R3: With sleep low, selN low and wrN low, every lane whose strobe is low takes its bits from dIn. Lanes whose strobe is high keep their stored value.
- R4: With selN low, wrN low and every strobe high, the cycle is aborted. No lane changes, and after that edge dOutEn is low.
- R5: With selN high at an edge, no access takes place whatever wrN and the strobes are, and after that edge dOutEn is low.
- R6: While sleep is high, dOutEn is low immediately, without a clock edge. Select, write and strobe inputs sampled during sleep have no effect on the array.
- R7: dOutEn is high only when the last sampled cycle was a read, oeN is low and sleep is low. oeN acts combinationally. dOut is all zeros whenever dOutEn is low.
- R8: A read of an address written in the directly preceding cycle returns the new bits in the written lanes and the old bits in the other lanes.
- R9: Stored words are kept through deselect, sleep and assertion of rst_n.
- R10: While rst_n is low and after it is released, dOutEn is low and dOut is zero until the first read.
- R11: With LANES set to 2, the word is 18 bits wide and lane writes and reads follow R1 to R3 over two lanes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the read register and valid flag only |
| addr | input | ADDR_W | Word address, sampled at the edge |
| dIn | input | LANES*9 | Write data |
| selN | input | 1 | Active-low select |
| wrN | input | 1 | Active-low global write |
| laneWrN | input | LANES | Active-low per-lane write strobes |
| sleep | input | 1 | Sleep request, forces drive off at once |
| oeN | input | 1 | Active-low output enable, combinational |
| dOut | output | LANES*9 | Read data, zero when not driven |
| dOutEn | output | 1 | High when the bus would be driven |

## Verification
Some properties are checked by assertions on every clock:

- the read valid flag follows the decoded read strobe exactly one cycle later;
- the read register holds its value when no read is decoded;
- drive only follows a sampled read cycle;
- the decoder issues no strobe during sleep or an aborted write;
- the decoder never raises a read and a lane write together.

Other behaviours can only be shown by the bench's scenarios, because they depend on what the array holds:

- that lane merging puts the right bits in the right place;
- that aborted, deselected and sleeping cycles leave the contents alone;
- that stored words survive reset;
- that a read returns merged data right after a partial write.

// File: rtl/lane_sram_pkg.sv
package lane_sram_pkg;

  // Widest supported configuration; narrower builds leave upper strobes low.
  localparam int MAX_LANES = 4;

  // Strobes issued by the control decoder to the datapath each cycle.
  typedef struct packed {
    logic                 rdEn;
    logic [MAX_LANES-1:0] laneWe;
  } ramStrobe_t;

endpackage

// File: rtl/lane_sram_ctrl.sv
module lane_sram_ctrl
  import lane_sram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             selN,
  input  logic             wrN,
  input  logic [LANES-1:0] laneWrN,
  input  logic             sleep,
  output ramStrobe_t       strobes
);

  typedef enum logic [1:0] {
    CYC_IDLE,
    CYC_READ,
    CYC_WRITE,
    CYC_ABORT
  } cycKind_e;

  cycKind_e cycKind;
  logic     anyLane;

  assign anyLane = |(~laneWrN);

  // Classify the sampled cycle; sleep overrides everything else.
  always_comb begin
    if (sleep || selN)      cycKind = CYC_IDLE;
    else if (wrN)           cycKind = CYC_READ;
    else if (anyLane)       cycKind = CYC_WRITE;
    else                    cycKind = CYC_ABORT;
  end

  always_comb begin
    strobes = '0;
    unique case (cycKind)
      CYC_READ:  strobes.rdEn = 1'b1;
      CYC_WRITE: strobes.laneWe[LANES-1:0] = ~laneWrN;
      default:   strobes = '0;
    endcase
  end

  // R6: no strobe reaches the datapath while asleep
  p_sleep_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (strobes == '0));

  // R4: aborted write issues neither read nor lane write
  p_abort_noop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !selN && !wrN && (&laneWrN)) |-> (strobes == '0));

  // R5: deselected cycle issues no access
  p_desel_noop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (selN) |-> (strobes == '0));

  // R2/R3: a read and a lane write are never issued together
  p_rw_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobes.rdEn && (|strobes.laneWe)));

endmodule

// File: rtl/lane_sram_datapath.sv
module lane_sram_datapath
  import lane_sram_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int LANE_BITS = 9,
  parameter int DEPTH     = 256,
  localparam int WORD_W   = LANES * LANE_BITS,
  localparam int ADDR_W   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ramStrobe_t        strobes,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] dIn,
  input  logic              sleep,
  input  logic              oeN,
  output logic [WORD_W-1:0] dOut,
  output logic              dOutEn
);

  logic [WORD_W-1:0] rdData;
  logic [WORD_W-1:0] rdWord;
  logic              readValid;

  // One storage array per lane (R1), no reset on contents (R9).
  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_BITS-1:0] laneMem [DEPTH];

    always_ff @(posedge clk) begin
      if (strobes.laneWe[g])
        laneMem[addr] <= dIn[g*LANE_BITS +: LANE_BITS];
    end

    assign rdWord[g*LANE_BITS +: LANE_BITS] = laneMem[addr];
  end

  // Registered read pipeline stage.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdData    <= '0;
      readValid <= 1'b0;
    end else begin
      readValid <= strobes.rdEn;
      if (strobes.rdEn)
        rdData <= rdWord;
    end
  end

  assign dOutEn = readValid && !oeN && !sleep;
  assign dOut   = dOutEn ? rdData : '0;

  // R2: valid follows a decoded read by one cycle
  p_read_pipe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.rdEn |=> readValid);

  // R5: any non-read cycle leaves the pipeline invalid
  p_idle_pipe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.rdEn |=> !readValid);

  // R9: captured read data is held when no read occurs
  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.rdEn |=> $stable(rdData));

endmodule

// File: rtl/lane_write_sram.sv
module lane_write_sram
  import lane_sram_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int DEPTH     = 256,
  localparam int LANE_BITS = 9,
  localparam int WORD_W    = LANES * LANE_BITS,
  localparam int ADDR_W    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] dIn,
  input  logic              selN,
  input  logic              wrN,
  input  logic [LANES-1:0]  laneWrN,
  input  logic              sleep,
  input  logic              oeN,
  output logic [WORD_W-1:0] dOut,
  output logic              dOutEn
);

  ramStrobe_t strobes;

  lane_sram_ctrl #(.LANES(LANES)) uCtrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .selN    (selN),
    .wrN     (wrN),
    .laneWrN (laneWrN),
    .sleep   (sleep),
    .strobes (strobes)
  );

  lane_sram_datapath #(
    .LANES     (LANES),
    .LANE_BITS (LANE_BITS),
    .DEPTH     (DEPTH)
  ) uData (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .addr    (addr),
    .dIn     (dIn),
    .sleep   (sleep),
    .oeN     (oeN),
    .dOut    (dOut),
    .dOutEn  (dOutEn)
  );

  // R2/R7: drive only follows an awake, selected read sampled at the previous edge
  p_out_from_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dOutEn |-> $past(!selN && wrN && !sleep));

  // R7: undriven output reads as zero
  p_zero_when_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dOutEn |-> (dOut == '0));

endmodule

// File: tb/lane_write_sram_test.sv
module lane_write_sram_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [35:0] dIn = '0;
  logic        selN = 1'b1, wrN = 1'b1, sleep = 1'b0, oeN = 1'b0;
  logic [3:0]  laneWrN = 4'hF;
  logic [35:0] dOut;
  logic        dOutEn;

  logic [7:0]  addr2 = '0;
  logic [17:0] dIn2 = '0;
  logic        selN2 = 1'b1, wrN2 = 1'b1;
  logic [1:0]  laneWrN2 = 2'b11;
  logic [17:0] dOut2;
  logic        dOutEn2;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_write_sram #(.LANES(4), .DEPTH(256)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .dIn(dIn), .selN(selN), .wrN(wrN),
    .laneWrN(laneWrN), .sleep(sleep), .oeN(oeN), .dOut(dOut), .dOutEn(dOutEn)
  );

  lane_write_sram #(.LANES(2), .DEPTH(256)) uut2 (
    .clk(clk), .rst_n(rst_n), .addr(addr2), .dIn(dIn2), .selN(selN2), .wrN(wrN2),
    .laneWrN(laneWrN2), .sleep(1'b0), .oeN(1'b0), .dOut(dOut2), .dOutEn(dOutEn2)
  );

  // Row: {selN, wrN, laneWrN[3:0], addr[7:0], dIn[35:0], expEn, expOut[35:0]}
  localparam logic [86:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 4'b0000, 8'd5,   36'h123456789, 1'b0, 36'h0},          // R3 full write
    {1'b0, 1'b1, 4'b1111, 8'd5,   36'h0,         1'b1, 36'h123456789},  // R2 read
    {1'b0, 1'b0, 4'b1110, 8'd5,   36'hFFFFFFFFF, 1'b0, 36'h0},          // R1 lane0 write
    {1'b0, 1'b1, 4'b1111, 8'd5,   36'h0,         1'b1, 36'h1234567FF},  // R8 merged read
    {1'b0, 1'b0, 4'b0111, 8'd5,   36'h0,         1'b0, 36'h0},          // R1 lane3 write
    {1'b0, 1'b1, 4'b1111, 8'd5,   36'h0,         1'b1, 36'h0034567FF},  // R3
    {1'b0, 1'b0, 4'b1111, 8'd5,   36'hFFFFFFFFF, 1'b0, 36'h0},          // R4 abort
    {1'b0, 1'b1, 4'b1111, 8'd5,   36'h0,         1'b1, 36'h0034567FF},  // R4 unchanged
    {1'b1, 1'b1, 4'b1111, 8'd5,   36'h0,         1'b0, 36'h0},          // R5 deselect
    {1'b1, 1'b0, 4'b0000, 8'd5,   36'h0,         1'b0, 36'h0},          // R5 deselected write
    {1'b0, 1'b1, 4'b1111, 8'd5,   36'h0,         1'b1, 36'h0034567FF},  // R5 unchanged
    {1'b0, 1'b0, 4'b1001, 8'd5,   36'hAAAAAAAAA, 1'b0, 36'h0},          // R3 lanes 1,2
    {1'b0, 1'b1, 4'b1111, 8'd5,   36'h0,         1'b1, 36'h002AAABFF},  // R3 merge
    {1'b0, 1'b0, 4'b0000, 8'd200, 36'h987654321, 1'b0, 36'h0},          // R3 second addr
    {1'b0, 1'b1, 4'b1111, 8'd200, 36'h0,         1'b1, 36'h987654321},  // R2
    {1'b0, 1'b1, 4'b1111, 8'd5,   36'h0,         1'b1, 36'h002AAABFF}   // R2 back-to-back
  };

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [86:0] row);
    selN    = row[86];
    wrN     = row[85];
    laneWrN = row[84:81];
    addr    = row[80:73];
    dIn     = row[72:37];
  endtask

  task automatic doRead(input logic [7:0] a);
    @(negedge clk);
    selN = 1'b0; wrN = 1'b1; laneWrN = 4'hF; addr = a;
    @(negedge clk);
    selN = 1'b1;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 5000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    // R10: reset state
    repeat (3) @(negedge clk);
    chk("R10 en in reset", {35'd0, dOutEn}, 36'd0);
    chk("R10 data in reset", dOut, 36'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 en after reset", {35'd0, dOutEn}, 36'd0);

    // Vector table walk
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk($sformatf("vec %0d en", i-1), {35'd0, dOutEn}, {35'd0, VEC[i-1][36]});
        chk($sformatf("vec %0d data", i-1), dOut, VEC[i-1][35:0]);
      end
      drive(VEC[i]);
    end
    @(negedge clk);
    chk("vec last en", {35'd0, dOutEn}, {35'd0, VEC[NVEC-1][36]});
    chk("vec last data", dOut, VEC[NVEC-1][35:0]);
    selN = 1'b1; wrN = 1'b1; laneWrN = 4'hF;

    // R7: output enable gates combinationally
    oeN = 1'b1;
    doRead(8'd200);
    chk("R7 oeN high en", {35'd0, dOutEn}, 36'd0);
    chk("R7 oeN high data", dOut, 36'd0);
    #1 oeN = 1'b0;
    #1 chk("R7 oeN low en", {35'd0, dOutEn}, 36'd1);
    chk("R7 oeN low data", dOut, 36'h987654321);

    // R6: sleep drops drive at once and blocks a write
    doRead(8'd200);
    chk("R6 pre-sleep en", {35'd0, dOutEn}, 36'd1);
    #1 sleep = 1'b1;
    #1 chk("R6 sleep async hiz", {35'd0, dOutEn}, 36'd0);
    @(negedge clk);
    selN = 1'b0; wrN = 1'b0; laneWrN = 4'h0; addr = 8'd200; dIn = 36'h0;
    @(negedge clk);
    chk("R6 sleep write hiz", {35'd0, dOutEn}, 36'd0);
    selN = 1'b1; wrN = 1'b1; laneWrN = 4'hF;
    sleep = 1'b0;
    doRead(8'd200);
    chk("R6 R9 kept through sleep", dOut, 36'h987654321);

    // R9: contents survive reset
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 reset clears drive", {35'd0, dOutEn}, 36'd0);
    rst_n = 1'b1;
    doRead(8'd5);
    chk("R9 kept through reset", dOut, 36'h002AAABFF);

    // R11: two-lane build
    @(negedge clk);
    selN2 = 1'b0; wrN2 = 1'b0; laneWrN2 = 2'b00; addr2 = 8'd7; dIn2 = 18'h12345;
    @(negedge clk);
    laneWrN2 = 2'b01; dIn2 = 18'h3FFFF;
    @(negedge clk);
    wrN2 = 1'b1; laneWrN2 = 2'b11;
    @(negedge clk);
    selN2 = 1'b1;
    chk("R11 two-lane en", {35'd0, dOutEn2}, 36'd1);
    chk("R11 two-lane merge", {18'd0, dOut2}, 36'h3FF45);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule